// File: doc/BRIEF.md
# Bitplane Pixel Plot Cache

This block turns a stream of single-pixel plot commands into byte writes to a planar framebuffer held in external SRAM. It keeps a pen position (X, Y). Each plot command takes the current colour and the transparency mode, places one pixel at the pen, and then steps the pen one pixel to the right. Pixels collect in a cache that holds one row of one tile, which is eight horizontally adjacent pixels. The cached row goes to memory only in three cases: the row is full, an explicit flush command arrives, or a plot lands in a different row.

A write-out is a read-modify-write of every bitplane byte of that tile row. Pixels the cache never received keep whatever the SRAM already held. Tiles are numbered down each column first. The framebuffer starts at a screen base offset that the caller selects. The default configuration is 4 bits per pixel and a screen height of 128 pixels. The `busy` output is high while a write-out runs, and the caller waits for it to clear before issuing the next command.

Top module: `bitplane_plot_cache`

## Requirements
- R1: When the eighth pixel of a cached row is stored, the block writes that row out on its own, with one SRAM write for each bitplane (4 writes at 4 bpp).
- R2: `pos_wr` loads the pen from `pos_x`/`pos_y`. Each accepted plot advances `pen_x` by one, wrapping from 255 to 0.
- R3: No SRAM write happens while the cached row is incomplete, unless a flush command or a plot into another row arrives.
- R4: The byte address is scr_base*1024 + (tile_col*16 + tile_row)*32 + 2*(Y mod 8) + plane offset. Here tile_col = X/8 and tile_row = Y/8. The plane offsets are 0, 1, 16 and 17 for planes 0 to 3.
- R5: A pixel with X mod 8 = 0 maps to bit 7 of each plane byte, and X mod 8 = 7 maps to bit 0. Bit p of the colour index goes to plane p.
- R6: Every write-out first reads the target byte and then writes it back. Bits of pixels not plotted into the cache keep their previous SRAM value.
- R7: When `zero_opaque` = 0, colour 0 is transparent. Such a plot stores nothing and never starts a write-out, but the pen still advances. When `zero_opaque` = 1, colour 0 is drawn like any other colour.
- R8: A `flush` command writes out a partly filled row. A flush with an empty cache performs no SRAM access.
- R9: A drawn plot into a row other than the cached one first writes out the old row. The new pixel then starts a fresh cache.
- R10: While `busy` is high, plot and flush commands are ignored, and the pen does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_wr | input | 1 | Load the pen position |
| pos_x | input | 8 | New pen X |
| pos_y | input | 7 | New pen Y |
| plot | input | 1 | Plot one pixel at the pen |
| flush | input | 1 | Write out the cached row |
| colour | input | 4 | Colour index for plots |
| zero_opaque | input | 1 | 1: colour 0 is drawn; 0: colour 0 is transparent |
| scr_base | input | 7 | Framebuffer base in 1 KiB units |
| busy | output | 1 | Write-out in progress; commands ignored |
| pen_x | output | 8 | Current pen X |
| mem_addr | output | 17 | SRAM byte address |
| mem_re | output | 1 | SRAM read strobe; data arrives the next cycle |
| mem_we | output | 1 | SRAM write strobe |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data |

## Verification
Several properties are checked on every cycle. Each SRAM write must follow a read of the same address, which covers the read-modify-write ordering. The pen must move by exactly one on an accepted plot and hold while busy. A full cache must start a write-out, and a pending pixel may only exist during a write-out. Other behaviour can only be shown by the bench's scenarios against a byte-level model of the framebuffer. These are the placement of pixels in column-major tiles and planar bytes, the preservation of untouched bits, the deferral of writes until a row completes, and the row-change and transparency cases. A full-screen sweep plots every pixel with a computed colour and compares the whole memory.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RD   = 2'd1,
      S_WR   = 2'd2
   } fl_state_e;
endpackage

// File: rtl/bpc_addr_gen.sv
// Maps a cached tile row and a plane index to a framebuffer byte address.
module bpc_addr_gen #(
   parameter int X_W        = 8,
   parameter int Y_W        = 7,
   parameter int ADDR_W     = 17,
   parameter int BASE_W     = 7,
   parameter int BASE_SHIFT = 10,
   parameter int TPC        = 16,
   parameter int BPP        = 4
) (
   input  logic [X_W-4:0]    tcol,
   input  logic [Y_W-1:0]    ty,
   input  logic [BASE_W-1:0] base,
   input  logic [1:0]        plane,
   output logic [ADDR_W-1:0] addr
);
   localparam int TILE_B = BPP * 8;

   logic [ADDR_W-1:0] tile_idx, base_off, fine_off;

   assign tile_idx = ADDR_W'(tcol) * ADDR_W'(TPC) + ADDR_W'(ty[Y_W-1:3]);
   assign base_off = ADDR_W'(base) << BASE_SHIFT;
   assign fine_off = ADDR_W'({ty[2:0], 1'b0})
                   + ADDR_W'({plane[1], 4'b0000})
                   + ADDR_W'(plane[0]);
   assign addr     = base_off + tile_idx * ADDR_W'(TILE_B) + fine_off;
endmodule

// File: rtl/bpc_plane_merge.sv
// Builds one plane byte from cached pixels, keeping old bits of unplotted pixels.
module bpc_plane_merge #(
   parameter int BPP = 4
) (
   input  logic [7:0][BPP-1:0] pix,
   input  logic [7:0]          mask,
   input  logic [1:0]          plane,
   input  logic [7:0]          old_byte,
   output logic [7:0]          new_byte
);
   logic [7:0] pbits, mbits;

   for (genvar i = 0; i < 8; i++) begin : g_pix
      if (BPP == 2) begin : g_two
         assign pbits[7-i] = pix[i][plane[0]];
      end else begin : g_four
         assign pbits[7-i] = pix[i][plane];
      end
      assign mbits[7-i] = mask[i];
   end

   assign new_byte = (old_byte & ~mbits) | (pbits & mbits);
endmodule

// File: rtl/bitplane_plot_cache.sv
module bitplane_plot_cache
   import bpc_pkg::*;
#(
   parameter int X_W        = 8,
   parameter int HEIGHT     = 128,
   parameter int BPP        = 4,
   parameter int ADDR_W     = 17,
   parameter int BASE_W     = 7,
   parameter int BASE_SHIFT = 10,
   localparam int Y_W       = $clog2(HEIGHT),
   localparam int TC_W      = X_W - 3,
   localparam int TPC       = HEIGHT / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pos_wr,
   input  logic [X_W-1:0]    pos_x,
   input  logic [Y_W-1:0]    pos_y,
   input  logic              plot,
   input  logic              flush,
   input  logic [BPP-1:0]    colour,
   input  logic              zero_opaque,
   input  logic [BASE_W-1:0] scr_base,
   output logic              busy,
   output logic [X_W-1:0]    pen_x,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   if (BPP != 2 && BPP != 4) begin : g_bad_bpp
      $error("bitplane_plot_cache: BPP must be 2 or 4");
   end
   if (HEIGHT % 8 != 0 || HEIGHT < 16) begin : g_bad_h
      $error("bitplane_plot_cache: HEIGHT must be a multiple of 8, at least 16");
   end
   if (BASE_W + BASE_SHIFT > ADDR_W || X_W < 4) begin : g_bad_w
      $error("bitplane_plot_cache: inconsistent address widths");
   end

   fl_state_e           st;
   logic [1:0]          plane;
   logic [Y_W-1:0]      pen_y;
   logic [7:0]          mask;
   logic [7:0][BPP-1:0] pix;
   logic [TC_W-1:0]     row_tc;
   logic [Y_W-1:0]      row_y;
   logic                pend_v;
   logic [2:0]          pend_idx;
   logic [BPP-1:0]      pend_col;
   logic [TC_W-1:0]     pend_tc;
   logic [Y_W-1:0]      pend_y;

   logic draw, accept, same_row, start_fl;

   assign draw     = (colour != '0) || zero_opaque;
   assign busy     = (st != S_IDLE) || (&mask) || pend_v;
   assign accept   = plot && !busy;
   assign same_row = (mask == '0) ||
                     ((pen_x[X_W-1:3] == row_tc) && (pen_y == row_y));
   assign start_fl = (st == S_IDLE) &&
                     ((&mask) ||
                      (flush && !busy && (|mask)) ||
                      (accept && draw && !same_row));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pen_x <= '0;
         pen_y <= '0;
      end else if (pos_wr) begin
         pen_x <= pos_x;
         pen_y <= pos_y;
      end else if (accept) begin
         pen_x <= pen_x + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         plane    <= '0;
         mask     <= '0;
         pix      <= '0;
         row_tc   <= '0;
         row_y    <= '0;
         pend_v   <= 1'b0;
         pend_idx <= '0;
         pend_col <= '0;
         pend_tc  <= '0;
         pend_y   <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (accept && draw && same_row) begin
                  mask[pen_x[2:0]] <= 1'b1;
                  pix[pen_x[2:0]]  <= colour;
                  row_tc           <= pen_x[X_W-1:3];
                  row_y            <= pen_y;
               end
               if (accept && draw && !same_row) begin
                  pend_v   <= 1'b1;
                  pend_idx <= pen_x[2:0];
                  pend_col <= colour;
                  pend_tc  <= pen_x[X_W-1:3];
                  pend_y   <= pen_y;
               end
               if (start_fl) begin
                  st    <= S_RD;
                  plane <= '0;
               end
            end
            S_RD: st <= S_WR;
            S_WR: begin
               if (plane == 2'(BPP - 1)) begin
                  st   <= S_IDLE;
                  mask <= '0;
                  if (pend_v) begin
                     mask           <= 8'(1) << pend_idx;
                     pix[pend_idx]  <= pend_col;
                     row_tc         <= pend_tc;
                     row_y          <= pend_y;
                     pend_v         <= 1'b0;
                  end
               end else begin
                  plane <= plane + 1'b1;
                  st    <= S_RD;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   bpc_addr_gen #(
      .X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
      .BASE_SHIFT(BASE_SHIFT), .TPC(TPC), .BPP(BPP)
   ) addr_i (
      .tcol(row_tc), .ty(row_y), .base(scr_base), .plane(plane), .addr(mem_addr)
   );

   bpc_plane_merge #(.BPP(BPP)) merge_i (
      .pix(pix), .mask(mask), .plane(plane),
      .old_byte(mem_rdata), .new_byte(mem_wdata)
   );

   assign mem_re = (st == S_RD);
   assign mem_we = (st == S_WR);

   // R6: every write targets the byte read on the previous cycle
   a_r6_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

   // R2: an accepted plot steps the pen by one
   a_r2_pen_step: assert property (@(posedge clk) disable iff (!rst_n)
      (plot && !busy && !pos_wr) |=> pen_x == $past(pen_x) + 1'b1);

   // R10: commands during a write-out leave the pen alone
   a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (plot && busy && !pos_wr) |=> pen_x == $past(pen_x));

   // R1: a full row in idle starts the read phase on the next cycle
   a_r1_full_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && (&mask)) |=> mem_re);

   // R9: a held pixel only exists while the old row is being written
   a_r9_pend_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |-> st != S_IDLE);

   // R3: no memory access starts from an idle, incomplete cache without a trigger
   a_r3_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !(&mask) && !flush && !plot) |=> !mem_re);
endmodule

// File: tb/bitplane_plot_cache_tb_top.sv
module bitplane_plot_cache_tb_top;
   localparam int MEM_N = 131072;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pos_wr = 1'b0;
   logic [7:0]  pos_x = '0;
   logic [6:0]  pos_y = '0;
   logic        plot = 1'b0;
   logic        flush = 1'b0;
   logic [3:0]  colour = '0;
   logic        zero_opaque = 1'b0;
   logic [6:0]  scr_base = '0;
   logic        busy;
   logic [7:0]  pen_x;
   logic [16:0] mem_addr;
   logic        mem_re, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   logic [7:0] mem  [MEM_N];
   logic [7:0] refm [MEM_N];

   int checks = 0;
   int errors = 0;
   int wr_count = 0;
   bit done = 1'b0;
   int bx = 0;
   int by = 0;

   always #5 clk = ~clk;

   bitplane_plot_cache dut_i (
      .clk(clk), .rst_n(rst_n), .pos_wr(pos_wr), .pos_x(pos_x), .pos_y(pos_y),
      .plot(plot), .flush(flush), .colour(colour), .zero_opaque(zero_opaque),
      .scr_base(scr_base), .busy(busy), .pen_x(pen_x), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   function automatic int init_val(int a);
      return (a * 37 + 11) & 255;
   endfunction

   function automatic int byte_addr(int base, int x, int y, int p);
      return (base * 1024 + ((x / 8) * 16 + (y / 8)) * 32 + (y % 8) * 2
              + (p / 2) * 16 + (p % 2)) % MEM_N;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic set_pos(int x, int y);
      settle();
      pos_x = 8'(x); pos_y = 7'(y); pos_wr = 1'b1;
      @(negedge clk);
      pos_wr = 1'b0;
      bx = x; by = y;
   endtask

   task automatic do_plot(int c, bit zo);
      settle();
      colour = 4'(c); zero_opaque = zo; plot = 1'b1;
      if (c != 0 || zo) begin
         for (int p = 0; p < 4; p++) begin
            int a = byte_addr(int'(scr_base), bx, by, p);
            refm[a][7 - (bx % 8)] = (c >> p) & 1;
         end
      end
      @(negedge clk);
      plot = 1'b0;
      bx = (bx + 1) % 256;
   endtask

   task automatic do_flush();
      settle();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      settle();
   endtask

   task automatic compare_all(string tag);
      int bad = 0;
      int first = -1;
      for (int a = 0; a < MEM_N; a++) begin
         if (mem[a] !== refm[a]) begin
            bad++;
            if (first < 0) first = a;
         end
      end
      if (first < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, {tag, " byte mismatch"}, int'(mem[first]), int'(refm[first]));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int w;
      for (int a = 0; a < MEM_N; a++) begin
         mem[a]  = 8'(init_val(a));
         refm[a] = 8'(init_val(a));
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!busy && !mem_we && !mem_re, "reset idle", {busy, mem_we, mem_re}, 0);
      chk(pen_x == 8'd0, "R2 reset pen", pen_x, 0);

      // R2: load and step, including wrap
      set_pos(250, 3);
      do_plot(1, 1'b1);
      chk(pen_x == 8'd251, "R2 pen step", pen_x, 251);
      set_pos(255, 3);
      do_plot(2, 1'b1);
      chk(pen_x == 8'd0, "R2 pen wrap", pen_x, 0);
      do_flush();
      compare_all("R2 flushed pixels");

      // R3 / R1 / R5: deferred full-row write
      set_pos(0, 0);
      w = wr_count;
      for (int k = 0; k < 7; k++) do_plot(k + 1, 1'b0);
      settle();
      chk(wr_count == w, "R3 no write before row full", wr_count - w, 0);
      do_plot(8, 1'b0);
      // R10: command presented while the automatic write-out is busy
      chk(busy, "R10 busy after full row", busy, 1);
      plot = 1'b1; colour = 4'd3;
      @(negedge clk);
      plot = 1'b0;
      chk(pen_x == 8'd8, "R10 plot ignored while busy", pen_x, 8);
      settle();
      chk(wr_count == w + 4, "R1 four plane writes", wr_count - w, 4);
      chk(mem[0] == 8'hAA, "R5 plane0 bit order", mem[0], 8'hAA);
      chk(mem[17] == 8'h01, "R4 plane3 offset", mem[17], 8'h01);
      compare_all("R1 full row");

      // R8: flush with empty cache does nothing
      w = wr_count;
      do_flush();
      chk(wr_count == w, "R8 empty flush", wr_count - w, 0);

      // R7 / R6 / R4: partial row, transparency, column-major tile 16
      set_pos(8, 0);
      do_plot(15, 1'b0);
      do_plot(0, 1'b0);
      settle();
      chk(pen_x == 8'd10, "R7 pen moves on transparent", pen_x, 10);
      do_plot(0, 1'b1);
      w = wr_count;
      settle();
      chk(wr_count == w, "R3 partial row held", wr_count - w, 0);
      do_flush();
      chk(wr_count == w + 4, "R8 partial flush", wr_count - w, 4);
      chk(mem[512] == 8'((init_val(512) | 8'h80) & ~8'h20), "R6 R4 merged byte",
          mem[512], (init_val(512) | 8'h80) & ~8'h20);
      compare_all("R6 preserve");

      // R9: plot into another row flushes first
      set_pos(0, 9);
      do_plot(6, 1'b1);
      w = wr_count;
      set_pos(0, 10);
      do_plot(3, 1'b1);
      settle();
      chk(wr_count == w + 4, "R9 row change flush", wr_count - w, 4);
      do_flush();
      chk(wr_count == w + 8, "R9 new pixel kept", wr_count - w, 8);
      compare_all("R9 rows");

      // R7: transparent plot in another row triggers nothing
      set_pos(0, 20);
      do_plot(5, 1'b0);
      w = wr_count;
      set_pos(0, 21);
      do_plot(0, 1'b0);
      settle();
      chk(wr_count == w, "R7 transparent no flush", wr_count - w, 0);
      do_flush();
      compare_all("R7 transparency");

      // R4: screen base offset
      scr_base = 7'd3;
      set_pos(40, 100);
      for (int k = 0; k < 4; k++) do_plot(k + 9, 1'b0);
      do_flush();
      compare_all("R4 base offset");

      // full-screen sweep with computed colours
      scr_base = 7'd1;
      for (int y = 0; y < 128; y++) begin
         set_pos(0, y);
         for (int x = 0; x < 256; x++) do_plot((x * 3 + y) & 15, y[0]);
      end
      do_flush();
      compare_all("R1 R4 R5 R6 sweep");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule